// File: doc/BRIEF.md
# Single-byte I2C master with clock-stretch wait and stuck-clock fault

This block is a bus master that moves exactly one byte over a two-wire I2C bus. A command gives a 7-bit target address, a read/write flag and, for writes, one data byte. The master then makes a START, shifts out the address and direction bit, checks the target's acknowledge, moves one data byte in the direction asked, handles the acknowledge slot that follows, and ends with a STOP. When it finishes it reports the received byte, a flag for an address NACK and a flag for a data NACK.

Both lines are open-drain. The block never drives a line high. It has one output-enable per line, and a 1 on that enable pulls the line low. It reads both lines back through a two-flop synchroniser. After the master releases SCL it waits until SCL reads back high before it times the high half of the bit, so a target may hold the clock low for as long as it needs. A watchdog counts the cycles that SCL stays low during a transfer. If that count reaches a limit, the master abandons the transfer, releases both lines and raises a bus-fault flag.

The sequencer has nine states. Each bit uses the same loop: ST_LOW_A, then ST_LOW_B, then ST_RISE, then ST_HIGH_A, then ST_HIGH_B. The states and transitions are:

- ST_IDLE goes to ST_START when a command is offered.
- ST_START goes to ST_LOW_A after one quarter bit.
- ST_LOW_A goes to ST_LOW_B after one quarter.
- ST_LOW_B goes to ST_RISE after one quarter.
- ST_RISE goes to ST_HIGH_A when SCL reads high. If the STOP is pending, it goes to ST_STOP_HOLD instead.
- ST_HIGH_A goes to ST_HIGH_B after one quarter. SDA is sampled at this point.
- ST_HIGH_B goes back to ST_LOW_A after one quarter.
- ST_STOP_HOLD goes to ST_STOP_REL after one quarter.
- ST_STOP_REL goes to ST_IDLE after one quarter.
- A watchdog expiry forces any state to ST_IDLE.

A separate phase register tracks where the transfer stands: address byte, address acknowledge, data byte, data acknowledge, or STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `busy`, `done`, all three flags, `scl_oe` and `sda_oe` are 0. While `busy` is 0, both enables stay 0, so both lines are released.
- R2: START pulls SDA low (`sda_oe` 1) while SCL is released. STOP releases SDA while SCL is released. Outside these two events, `sda_oe` changes only while `scl_oe` is 1. So a bus monitor sees exactly one START and one STOP per transfer.
- R3: The first byte on the bus is the 7 address bits, MSB first, followed by the direction bit (0 = write, 1 = read). In the ninth clock the master releases SDA, and a low level in that slot counts as the target's ACK.
- R4: On a write, the data byte is sent MSB first. `data_nack` becomes 1 when SDA reads high in the following acknowledge slot, and 0 when SDA reads low there.
- R5: On a read, the master releases SDA for eight clocks and assembles the sampled bits MSB first into `rdata`. It leaves SDA released in the final acknowledge slot, which signals NACK, and `data_nack` stays 0.
- R6: On an address NACK, `addr_nack` becomes 1 and no data clocks follow. Only the STOP clock comes after the address acknowledge, so SCL rises 10 times in total. `addr_nack` and `data_nack` are never 1 together.
- R7: After releasing SCL, the master does not pull SCL low again until it has seen SCL read high. The high half of a bit is timed from that point, so it is at least 2×`QUARTER_CLKS` cycles long even when a target stretched the clock.
- R8: If SCL reads low for `STUCK_LIMIT` consecutive cycles during a transfer, the master goes idle. It releases both lines, sets `bus_fault` to 1, clears `busy` and pulses `done`.
- R9: `busy` goes to 1 in the cycle after a command is accepted and stays 1 until the transfer ends. While `busy` is 1, new commands are ignored. `done` is a one-cycle pulse with `busy` already 0. Accepting a command clears all three flags.
- R10: Without stretching, every SCL low phase lasts exactly 2×`QUARTER_CLKS` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Offers a command; taken when the block is idle |
| cmd_addr | input | 7 | Target address |
| cmd_read | input | 1 | Direction: 1 = read, 0 = write |
| cmd_wdata | input | 8 | Byte to send on a write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends or is aborted |
| rdata | output | 8 | Byte received by the last read |
| addr_nack | output | 1 | Target did not acknowledge the address |
| data_nack | output | 1 | Target did not acknowledge the written byte |
| bus_fault | output | 1 | Transfer aborted because SCL stayed low too long |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | SCL level read back from the bus |
| sda_in | input | 1 | SDA level read back from the bus |

## Verification
The bench builds the master with `QUARTER_CLKS` = 4 and `STUCK_LIMIT` = 64. With these values a bit lasts about twenty cycles, so every frame shape finishes in a few hundred cycles: write, write with data NACK, read, and address NACK. A 30-cycle stretch sits well inside the fault limit and must not trip it. A target that holds SCL low for good reaches the limit within about seventy cycles, which makes both the abort and the clean transfer that follows it cheap to observe.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    // Bit-level sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_LOW_A,
        ST_LOW_B,
        ST_RISE,
        ST_HIGH_A,
        ST_HIGH_B,
        ST_STOP_HOLD,
        ST_STOP_REL
    } mst_state_e;

    // Position within the frame
    typedef enum logic [2:0] {
        PH_ADDR,
        PH_AACK,
        PH_DATA,
        PH_DACK,
        PH_STOP
    } phase_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int   WIDTH     = 2,
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {(STAGES*WIDTH){RST_LEVEL}};
                else        stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {(STAGES*WIDTH){RST_LEVEL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/i2cm_qtimer.sv
module i2cm_qtimer #(
    parameter int COUNT = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/i2cm_stuck_wd.sv
module i2cm_stuck_wd #(
    parameter int LIMIT = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic line_low,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          counting;

    assign counting = armed && line_low;
    assign expire   = counting && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!counting || expire) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int QUARTER_CLKS = 125,
    parameter int STUCK_LIMIT  = 6_250_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_read,
    input  logic [BYTE_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rdata,
    output logic              addr_nack,
    output logic              data_nack,
    output logic              bus_fault,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              scl_in,
    input  logic              sda_in
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    mst_state_e        state_q, state_nxt;
    phase_e            phase_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] wd_q;
    logic              rd_q;

    logic scl_s, sda_s;
    logic q_run, q_tick;
    logic wd_expire;
    logic accept, sample, last_bit;
    logic bit_pull, sda_nxt;

    // Line synchroniser
    i2cm_sync #(
        .WIDTH    (2),
        .STAGES   (2),
        .RST_LEVEL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({scl_in, sda_in}),
        .q    ({scl_s, sda_s})
    );

    // Quarter-bit timer
    assign q_run = (state_q != ST_IDLE) && (state_q != ST_RISE);

    i2cm_qtimer #(
        .COUNT(QUARTER_CLKS)
    ) u_qtimer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q_run),
        .tick (q_tick)
    );

    // Stuck-low clock watchdog
    i2cm_stuck_wd #(
        .LIMIT(STUCK_LIMIT)
    ) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (state_q != ST_IDLE),
        .line_low(!scl_s),
        .expire  (wd_expire)
    );

    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign sample   = (state_q == ST_HIGH_A) && q_tick;
    assign last_bit = (bit_q == LAST_BIT);

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:      if (cmd_valid) state_nxt = ST_START;
            ST_START:     if (q_tick)    state_nxt = ST_LOW_A;
            ST_LOW_A:     if (q_tick)    state_nxt = ST_LOW_B;
            ST_LOW_B:     if (q_tick)    state_nxt = ST_RISE;
            ST_RISE: begin
                if (scl_s) state_nxt = (phase_q == PH_STOP) ? ST_STOP_HOLD : ST_HIGH_A;
            end
            ST_HIGH_A:    if (q_tick)    state_nxt = ST_HIGH_B;
            ST_HIGH_B:    if (q_tick)    state_nxt = ST_LOW_A;
            ST_STOP_HOLD: if (q_tick)    state_nxt = ST_STOP_REL;
            ST_STOP_REL:  if (q_tick)    state_nxt = ST_IDLE;
            default:                     state_nxt = ST_IDLE;
        endcase
        if (wd_expire) state_nxt = ST_IDLE;
    end

    // Level the master places on SDA for the current phase (1 = pull low)
    always_comb begin
        unique case (phase_q)
            PH_ADDR: bit_pull = !sh_q[BYTE_W-1];
            PH_DATA: bit_pull = !rd_q && !sh_q[BYTE_W-1];
            PH_STOP: bit_pull = 1'b1;
            default: bit_pull = 1'b0;
        endcase
    end

    always_comb begin
        unique case (state_nxt)
            ST_IDLE:      sda_nxt = 1'b0;
            ST_START:     sda_nxt = 1'b1;
            ST_LOW_B:     sda_nxt = bit_pull;
            ST_STOP_HOLD: sda_nxt = 1'b1;
            ST_STOP_REL:  sda_nxt = 1'b0;
            default:      sda_nxt = sda_oe;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            scl_oe <= (state_nxt == ST_LOW_A) || (state_nxt == ST_LOW_B);
            sda_oe <= sda_nxt;
            busy   <= (state_nxt != ST_IDLE);
            done   <= (state_q != ST_IDLE) && (state_nxt == ST_IDLE);
        end
    end

    // Frame datapath: shift register, phase, result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= PH_ADDR;
            bit_q     <= '0;
            sh_q      <= '0;
            wd_q      <= '0;
            rd_q      <= 1'b0;
            rdata     <= '0;
            addr_nack <= 1'b0;
            data_nack <= 1'b0;
            bus_fault <= 1'b0;
        end else if (wd_expire) begin
            bus_fault <= 1'b1;
        end else if (accept) begin
            sh_q      <= {cmd_addr, cmd_read};
            wd_q      <= cmd_wdata;
            rd_q      <= cmd_read;
            phase_q   <= PH_ADDR;
            bit_q     <= '0;
            addr_nack <= 1'b0;
            data_nack <= 1'b0;
            bus_fault <= 1'b0;
        end else if (sample) begin
            unique case (phase_q)
                PH_ADDR, PH_DATA: begin
                    sh_q <= {sh_q[BYTE_W-2:0], sda_s};
                    if (last_bit) begin
                        bit_q   <= '0;
                        phase_q <= (phase_q == PH_ADDR) ? PH_AACK : PH_DACK;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                PH_AACK: begin
                    if (sda_s) begin
                        addr_nack <= 1'b1;
                        phase_q   <= PH_STOP;
                    end else begin
                        phase_q <= PH_DATA;
                        sh_q    <= rd_q ? '0 : wd_q;
                    end
                end
                PH_DACK: begin
                    if (rd_q) rdata     <= sh_q;
                    else      data_nack <= sda_s;
                    phase_q <= PH_STOP;
                end
                default: phase_q <= PH_STOP;
            endcase
        end
    end

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
#(
    parameter int STUCK_LIMIT = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       scl_in,
    input logic       busy,
    input logic       done,
    input logic       addr_nack,
    input logic       data_nack,
    input logic       bus_fault,
    input mst_state_e state_q
);

    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_run <= 0;
        else if (busy && !scl_in) low_run <= low_run + 1;
        else                      low_run <= 0;
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R1

    AST_SDA_MOVES_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (scl_oe || state_q == ST_START || state_q == ST_STOP_REL || state_q == ST_IDLE)); // R2

    AST_NO_EDGE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(scl_in)); // R7

    AST_LOW_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (low_run <= STUCK_LIMIT + 3)); // R8

    AST_FAULT_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_fault) |-> (!busy && done)); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

    AST_NACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_nack && data_nack)); // R6

endmodule

bind i2c_byte_master i2cm_checker #(.STUCK_LIMIT(STUCK_LIMIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .scl_in   (scl_in),
    .busy     (busy),
    .done     (done),
    .addr_nack(addr_nack),
    .data_nack(data_nack),
    .bus_fault(bus_fault),
    .state_q  (state_q)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;

    localparam int Q   = 4;
    localparam int LIM = 64;
    localparam logic [6:0] TGT = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic       cmd_read = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic       busy, done, addr_nack, data_nack, bus_fault, scl_oe, sda_oe;
    logic [7:0] rdata;
    logic       scl_line, sda_line;

    // bench-owned target state (written only by the monitor process)
    logic t_scl_low = 1'b0;
    logic t_sda_low = 1'b0;

    // configuration (written only by the initial process)
    logic       stat_clr = 1'b0;
    int         stretch_k = 99;
    int         stretch_len = 0;
    int         stuck_k = 99;
    logic       ack_data = 1'b1;
    logic [7:0] rd_src = 8'hC3;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign scl_line = !(scl_oe || t_scl_low);
    assign sda_line = !(sda_oe || t_sda_low);

    i2c_byte_master #(
        .QUARTER_CLKS(Q),
        .STUCK_LIMIT (LIM)
    ) u_i2c_byte_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_addr (cmd_addr),
        .cmd_read (cmd_read),
        .cmd_wdata(cmd_wdata),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .addr_nack(addr_nack),
        .data_nack(data_nack),
        .bus_fault(bus_fault),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .scl_in   (scl_line),
        .sda_in   (sda_line)
    );

    // Bus monitor and target model
    logic       scl_p = 1'b1, sda_p = 1'b1;
    logic       active = 1'b0, matched = 1'b0, is_rd = 1'b0, stuck_hold = 1'b0, ack_seen = 1'b0;
    logic [7:0] acap = '0, wcap = '0;
    int k = 0, run = 0, stretch_left = 0;
    int start_cnt = 0, stop_cnt = 0, rise_cnt = 0;
    int min_low = 1000000, max_low = 0, min_high = 1000000;

    always @(negedge clk) begin
        if (stat_clr) begin
            start_cnt = 0; stop_cnt = 0; rise_cnt = 0;
            min_low = 1000000; max_low = 0; min_high = 1000000;
            active = 1'b0; stuck_hold = 1'b0; stretch_left = 0;
            t_sda_low = 1'b0; ack_seen = 1'b0; matched = 1'b0;
        end
        if (scl_line && scl_p && sda_p && !sda_line) begin
            start_cnt++; k = 0; active = 1'b1;
        end
        if (scl_line && scl_p && !sda_p && sda_line) begin
            stop_cnt++; active = 1'b0; t_sda_low = 1'b0;
        end
        if (!scl_p && scl_line) begin
            rise_cnt++;
            k++;
            if (k <= 8) acap = {acap[6:0], sda_line};
            else if (k >= 10 && k <= 17) wcap = {wcap[6:0], sda_line};
            if (k == 18) ack_seen = sda_line;
        end
        if (scl_p && !scl_line && active) begin
            if (k == 8) begin
                matched   = (acap[7:1] == TGT);
                is_rd     = acap[0];
                t_sda_low = matched;
            end else if (k >= 9 && k <= 16) begin
                t_sda_low = matched && is_rd && !rd_src[16-k];
            end else if (k == 17) begin
                t_sda_low = matched && !is_rd && ack_data;
            end else begin
                t_sda_low = 1'b0;
            end
            if (k == stretch_k) stretch_left = stretch_len;
            if (k == stuck_k)   stuck_hold = 1'b1;
        end
        if (scl_line != scl_p) begin
            if (!scl_p) begin
                if (run < min_low) min_low = run;
                if (run > max_low) max_low = run;
            end else if (run < min_high) begin
                min_high = run;
            end
            run = 1;
        end else begin
            run++;
        end
        if (stretch_left > 0) begin
            t_scl_low = 1'b1;
            stretch_left--;
        end else begin
            t_scl_low = stuck_hold;
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    // Check helpers
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input string what, input int act, input int bound);
        checks++;
        if (act < bound) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, bound);
        end
    endtask

    task automatic clear_stats();
        @(posedge clk) stat_clr = 1'b1;
        @(posedge clk) stat_clr = 1'b0;
    endtask

    task automatic issue(input logic [6:0] a, input logic rd, input logic [7:0] wd);
        @(negedge clk);
        cmd_addr = a; cmd_read = rd; cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    // Scenarios
    task automatic t_reset();
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "scl_oe after reset", scl_oe, 0);
        chk("R1", "sda_oe after reset", sda_oe, 0);
        chk("R1", "flags after reset", {addr_nack, data_nack, bus_fault, done}, 0);
    endtask

    task automatic t_write_ack();
        clear_stats();
        ack_data = 1'b1; stretch_k = 99; stuck_k = 99;
        issue(TGT, 1'b0, 8'hA6);
        chk("R9", "busy after accept", busy, 1);
        wait_done();
        chk("R9", "busy with done", busy, 0);
        chk("R4", "data_nack on ack", data_nack, 0);
        chk("R3", "addr_nack on ack", addr_nack, 0);
        @(posedge clk);
        chk("R3", "address+dir byte", acap, {TGT, 1'b0});
        chk("R4", "written byte", wcap, 8'hA6);
        chk("R2", "start count", start_cnt, 1);
        chk("R2", "stop count", stop_cnt, 1);
        chk("R10", "min low", min_low, 2*Q);
        chk("R10", "max low", max_low, 2*Q);
        chk_ge("R7", "min high", min_high, 2*Q);
        chk("R6", "rise count full frame", rise_cnt, 19);
    endtask

    task automatic t_write_nack();
        clear_stats();
        ack_data = 1'b0;
        issue(TGT, 1'b0, 8'h3C);
        wait_done();
        chk("R4", "data_nack on nack", data_nack, 1);
        chk("R6", "addr_nack on data nack", addr_nack, 0);
        @(posedge clk);
        chk("R4", "written byte nack case", wcap, 8'h3C);
        chk("R2", "stop after data nack", stop_cnt, 1);
        ack_data = 1'b1;
    endtask

    task automatic t_read();
        clear_stats();
        rd_src = 8'hC3;
        issue(TGT, 1'b1, 8'hFF);
        wait_done();
        chk("R5", "read byte", rdata, 8'hC3);
        chk("R5", "data_nack on read", data_nack, 0);
        @(posedge clk);
        chk("R3", "address+dir byte read", acap, {TGT, 1'b1});
        chk("R5", "master nack level", ack_seen, 1);
        clear_stats();
        rd_src = 8'h5E;
        issue(TGT, 1'b1, 8'h00);
        wait_done();
        chk("R5", "second read byte", rdata, 8'h5E);
    endtask

    task automatic t_addr_nack();
        clear_stats();
        issue(7'h21, 1'b0, 8'h99);
        wait_done();
        chk("R6", "addr_nack", addr_nack, 1);
        chk("R6", "data_nack with addr nack", data_nack, 0);
        @(posedge clk);
        chk("R6", "rise count short frame", rise_cnt, 10);
        chk("R2", "stop after addr nack", stop_cnt, 1);
        chk("R3", "address bits on nack", acap, {7'h21, 1'b0});
    endtask

    task automatic t_stretch();
        clear_stats();
        stretch_k = 8; stretch_len = 30;
        issue(TGT, 1'b0, 8'h81);
        wait_done();
        chk("R7", "no fault on stretch", bus_fault, 0);
        chk("R7", "ack after stretch", {addr_nack, data_nack}, 0);
        @(posedge clk);
        chk_ge("R7", "stretched low", max_low, 30);
        chk_ge("R7", "min high after stretch", min_high, 2*Q);
        chk("R7", "byte after stretch", wcap, 8'h81);
        stretch_k = 99;
    endtask

    task automatic t_busy_ignore();
        clear_stats();
        issue(TGT, 1'b0, 8'h0F);
        repeat (20) @(negedge clk);
        cmd_addr = 7'h11; cmd_read = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk("R9", "busy after ignored cmd", busy, 0);
        @(posedge clk);
        chk("R9", "single start", start_cnt, 1);
        chk("R9", "original address kept", acap, {TGT, 1'b0});
        chk("R9", "original data kept", wcap, 8'h0F);
    endtask

    task automatic t_timeout();
        clear_stats();
        stuck_k = 3;
        issue(TGT, 1'b0, 8'h77);
        wait_done();
        chk("R8", "bus_fault", bus_fault, 1);
        chk("R8", "busy after fault", busy, 0);
        chk("R8", "lines released", {scl_oe, sda_oe}, 0);
        stuck_k = 99;
        clear_stats();
        repeat (4) @(negedge clk);
        chk("R1", "idle enables after fault", {scl_oe, sda_oe}, 0);
        issue(TGT, 1'b0, 8'h5B);
        chk("R9", "fault cleared on accept", bus_fault, 0);
        wait_done();
        chk("R8", "recovery no fault", bus_fault, 0);
        @(posedge clk);
        chk("R8", "recovery byte", wcap, 8'h5B);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_write_ack();
        t_write_nack();
        t_read();
        t_addr_nack();
        t_stretch();
        t_busy_ignore();
        t_timeout();
        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule